// File: doc/BRIEF.md
# Scan Array Clear Sequencer

This controller brings every cell of a toggle-on-read scan array to logic 0. In that kind of array, each access returns the cell's current value and inverts the cell in the same operation. The sequencer cannot write a value directly. Instead it reads each cell once and looks at the result. If the cell returned 0, it now holds 1, so the sequencer accesses it a second time to flip it back. If the cell returned 1, it now holds 0 and needs nothing more.

Every cell gets a fixed two-cycle slot. The first cycle is always an access. The second cycle is either a repeat access to the same cell or an idle cycle with no strobe. The array's read path is registered, so the value returned by the first access is on `rd_bit` during the second cycle of the slot. The sequencer decides the second cycle's strobe from that value. Because the slot length is fixed, a full clear always takes exactly twice the cell count, whatever the array holds.

The cells are walked in row-major order. A one-cycle pulse on `start` launches a clear. When the last slot ends, `busy` drops and `done` pulses for one cycle.

Top module: `scan_clear_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `busy`=0, `done`=0, `strobe`=0, `row`=0 and `col`=0. While idle with no start, `strobe` stays 0.
- R2: A high `start` sampled at an edge while idle makes the next cycle the first cycle of the slot for row 0, column 0, with `busy`=1.
- R3: The first cycle of every slot has `strobe`=1 and presents that slot's cell address.
- R4: If `rd_bit` is 0 in the second cycle of a slot, `strobe` is 1 in that cycle and the address is unchanged from the first cycle.
- R5: If `rd_bit` is 1 in the second cycle of a slot, `strobe` is 0 in that cycle.
- R6: Slot k addresses row k / COLS and column k mod COLS. Column advances first, from 0 up to ROWS*COLS-1.
- R7: `busy` stays high for exactly 2*ROWS*COLS consecutive cycles per clear.
- R8: The cycle after the last slot has `done`=1 and `busy`=0. The cycle after that has `done`=0, and `row`/`col` are back to 0.
- R9: A `start` sampled while `busy` or `done` is high has no effect on the slot sequence or its length, and does not launch a new clear.
- R10: After a clear on an array with one-cycle registered toggle-on-read cells, every cell holds 0, whatever the starting contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a clear; honoured only while idle |
| rd_bit | input | 1 | Registered read bus: the value returned by the previous cycle's access |
| row | output | RW | Row address of the addressed cell |
| col | output | CW | Column address of the addressed cell |
| strobe | output | 1 | Access strobe: the addressed cell is read and inverted at the next edge |
| busy | output | 1 | High throughout the slot sequence |
| done | output | 1 | One-cycle pulse following the last slot |

## Verification
The assertions rely on three things about the inputs. First, `rd_bit` in the second cycle of a slot carries the value the first access returned, so there is exactly one register between the strobe edge and the read bus. Second, `start` is synchronous. Third, reset is held from time zero. The bench array model meets the first point by registering the addressed cell's old value on every strobed edge while inverting the cell. It changes `start`, `rst` and its preload control only on falling clock edges. This keeps the read bus and the requests inside the timing the checker assumes.

// File: rtl/scan_clear_pkg.sv
`timescale 1ns/1ps
package scan_clear_pkg;

  typedef enum logic [1:0] {
    SC_IDLE   = 2'd0,
    SC_FIRST  = 2'd1,
    SC_SECOND = 2'd2,
    SC_DONE   = 2'd3
  } sc_state_e;

  function automatic int sc_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scan_clear_addr.sv
`timescale 1ns/1ps
module scan_clear_addr #(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int RW   = 4,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          last
);

  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

  logic row_end;
  logic col_end;

  assign row_end = (row == ROW_MAX);
  assign col_end = (col == COL_MAX);
  assign last    = row_end && col_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row <= '0;
      col <= '0;
    end else if (adv) begin
      if (col_end) begin
        col <= '0;
        row <= row_end ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scan_clear_fsm.sv
`timescale 1ns/1ps
module scan_clear_fsm
  import scan_clear_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic rd_bit,
  input  logic last,
  output logic strobe,
  output logic busy,
  output logic done,
  output logic adv,
  output logic clr
);

  sc_state_e state_q;
  sc_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SC_IDLE:   if (start) state_d = SC_FIRST;
      SC_FIRST:  state_d = SC_SECOND;
      SC_SECOND: state_d = last ? SC_DONE : SC_FIRST;
      SC_DONE:   state_d = SC_IDLE;
      default:   state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SC_IDLE;
    else     state_q <= state_d;
  end

  // Second cycle repeats the access only when the first read returned 0.
  assign strobe = (state_q == SC_FIRST) || ((state_q == SC_SECOND) && !rd_bit);
  assign busy   = (state_q == SC_FIRST) || (state_q == SC_SECOND);
  assign done   = (state_q == SC_DONE);
  assign adv    = (state_q == SC_SECOND) && !last;
  assign clr    = (state_q == SC_SECOND) && last;

endmodule

// File: rtl/scan_clear_seq.sv
`timescale 1ns/1ps
module scan_clear_seq
  import scan_clear_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  localparam int RW  = sc_width(ROWS),
  localparam int CW  = sc_width(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rd_bit,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          strobe,
  output logic          busy,
  output logic          done
);

  logic last;
  logic adv;
  logic clr;

  scan_clear_addr #(
    .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)
  ) u_addr (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .adv  (adv),
    .row  (row),
    .col  (col),
    .last (last)
  );

  scan_clear_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .rd_bit (rd_bit),
    .last   (last),
    .strobe (strobe),
    .busy   (busy),
    .done   (done),
    .adv    (adv),
    .clr    (clr)
  );

endmodule

// File: rtl/scan_clear_chk.sv
`timescale 1ns/1ps
module scan_clear_chk #(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int RW   = 4,
  parameter int CW   = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          rd_bit,
  input logic [RW-1:0] row,
  input logic [CW-1:0] col,
  input logic          strobe,
  input logic          busy,
  input logic          done
);

  localparam logic [31:0] TOTAL = 32'(2 * ROWS * COLS);

  logic        second;
  logic [31:0] run_len;
  logic [31:0] lin;

  assign lin = 32'(row) * 32'(COLS) + 32'(col);

  always_ff @(posedge clk) begin
    if (rst) begin
      second  <= 1'b0;
      run_len <= '0;
    end else begin
      second  <= busy ? !second : 1'b0;
      if (busy)      run_len <= run_len + 1;
      else if (done) run_len <= '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !strobe); // R1

  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> (row == '0 && col == '0 && strobe)); // R2

  AST_FIRST_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (busy && !second) |-> strobe); // R3

  AST_REPEAT_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busy && second && !rd_bit) |-> (strobe && $stable(row) && $stable(col))); // R4

  AST_SKIP_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    (busy && second && rd_bit) |-> !strobe); // R5

  AST_ROW_MAJOR_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && !second && $past(busy)) |-> (lin == $past(lin) + 1)); // R6

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == TOTAL)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 (!done && row == '0 && col == '0))); // R8

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy); // R9

endmodule

bind scan_clear_seq scan_clear_chk #(
  .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .rd_bit (rd_bit),
  .row    (row),
  .col    (col),
  .strobe (strobe),
  .busy   (busy),
  .done   (done)
);

// File: tb/scan_clear_seq_bench.sv
`timescale 1ns/1ps
module scan_clear_seq_bench;

  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int N    = ROWS * COLS;
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          rd_q = 1'b0;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          strobe;
  logic          busy;
  logic          done;

  logic          load = 1'b0;
  logic [N-1:0]  load_pat = '0;
  logic [N-1:0]  cells = '0;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  scan_clear_seq #(.ROWS(ROWS), .COLS(COLS)) u_scan_clear_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .rd_bit (rd_q),
    .row    (row),
    .col    (col),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  int lin;
  assign lin = int'(row) * COLS + int'(col);

  // Array model: toggle on access, old value registered onto the read bus.
  always_ff @(posedge clk) begin
    if (load) begin
      cells <= load_pat;
    end else if (strobe && lin < N) begin
      cells[lin] <= ~cells[lin];
      rd_q       <= cells[lin];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset_idle();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(strobe == 1'b0, "R1 strobe", strobe, 0);
    chk(lin == 0, "R1 address", lin, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(strobe == 1'b0 && busy == 1'b0, "R1 idle quiet", {strobe, busy}, 0);
    end
  endtask

  task automatic run_clear(input logic [N-1:0] pat, input bit poke);
    @(negedge clk);
    load = 1'b1; load_pat = pat;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2 * N; i++) begin
      int k;
      k = i / 2;
      chk(busy == 1'b1, "R7 busy held", busy, 1);
      if (i % 2 == 0) begin
        if (i == 0) chk(lin == 0 && strobe, "R2 start at origin", lin, 0);
        chk(strobe == 1'b1, "R3 first access", strobe, 1);
        chk(lin == k, "R6 row-major", lin, k);
      end else if (pat[k] == 1'b0) begin
        chk(strobe == 1'b1, "R4 repeat strobe", strobe, 1);
        chk(lin == k, "R4 same address", lin, k);
      end else begin
        chk(strobe == 1'b0, "R5 idle second", strobe, 0);
      end
      start = (poke && (i == 5 || i == 2 * N - 1)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = poke;
    chk(done == 1'b1, "R8 done pulse", done, 1);
    chk(busy == 1'b0, "R7 busy ends", busy, 0);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8 done single", done, 0);
    chk(lin == 0, "R8 address home", lin, 0);
    chk(busy == 1'b0 && strobe == 1'b0, "R9 no restart", {busy, strobe}, 0);
    chk(cells == '0, "R10 array cleared", int'(cells), 0);
  endtask

  task automatic test_reset_mid_run();
    @(negedge clk);
    load = 1'b1; load_pat = 12'h5A3;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset mid run", {busy, done}, 0);
    chk(strobe == 1'b0, "R1 reset strobe", strobe, 0);
    chk(lin == 0, "R1 reset address", lin, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 stays idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset_idle();
    run_clear('0, 1'b0);
    run_clear('1, 1'b0);
    run_clear(12'hA5C, 1'b1);
    run_clear(12'h3C6, 1'b0);
    test_reset_mid_run();
    run_clear(12'h801, 1'b1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule